// File: doc/BRIEF.md
# Pixel Fade and Colour-Key Stage

This block is one stage of a texture-mapping pipeline. Each input item is a 16-bit RGB565 texture pixel with the destination address it is to be written to. The stage darkens the pixel by a programmable fade level, or drops it entirely when it equals a key colour and keying is on. Pixels that survive leave with their address untouched.

Both sides use a strobe/acknowledge handshake. A transfer completes in any cycle in which the strobe and the acknowledge are both high. A sender whose strobe is not acknowledged keeps the strobe high and holds its data. The stage owns a single output register. The upstream acknowledge depends only on whether that register is empty and on the downstream acknowledge, and never on the upstream strobe.

The fade level, key colour and key enable are static configuration inputs. They are changed only while no pixel is in flight.

Top module: `pix_fade_key`

## Requirements
- R1: After reset the stage holds no pixel: `dn_stb` is low and `up_ack` is high.
- R2: Each colour field is scaled separately as floor(c·(n+1)/64), where n is `fade_level`. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0, in both the input and the output pixel.
- R3: With `fade_level` = 0 every forwarded pixel is 0x0000.
- R4: With `fade_level` = 63 every forwarded pixel equals its input pixel.
- R5: With `key_enable` high, an accepted pixel equal to `key_color` produces no downstream transfer. It is still consumed: its upstream transfer completes like any other.
- R6: With `key_enable` low, a pixel equal to `key_color` is forwarded, scaled as usual.
- R7: The key comparison uses the unscaled input pixel. A pixel whose faded value equals the key, but whose raw value does not, is forwarded.
- R8: `dn_addr` equals the `up_addr` of the same pixel.
- R9: While `dn_stb` is high and `dn_ack` is low, `dn_stb`, `dn_pixel` and `dn_addr` stay unchanged in the next cycle.
- R10: `up_ack` is high when the output register is empty or when `dn_ack` is high. It is low when a pixel waits and `dn_ack` is low.
- R11: A forwarded pixel appears on `dn_stb`/`dn_pixel` in the cycle after its upstream transfer.
- R12: With `dn_ack` held high, pixels stream at one per cycle and leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fade_level | input | 6 | Fade level n; the scale is (n+1)/64 |
| key_color | input | 16 | RGB565 value to discard |
| key_enable | input | 1 | Enables discarding of key-coloured pixels |
| up_stb | input | 1 | Upstream pixel valid |
| up_ack | output | 1 | Stage can take a pixel this cycle |
| up_pixel | input | 16 | Upstream RGB565 texture pixel |
| up_addr | input | ADDR_W | Upstream destination address |
| dn_stb | output | 1 | Downstream pixel valid |
| dn_ack | input | 1 | Downstream accepts the pixel |
| dn_pixel | output | 16 | Faded RGB565 pixel |
| dn_addr | output | ADDR_W | Destination address, passed through |

## Verification
Several properties are checked in every cycle: stall stability, the relation of `up_ack` to register occupancy and `dn_ack`, one-cycle latency with the address carried along, the absence of output for a dropped key pixel, and the two end points of the fade range. The bench scenarios are needed for the behaviour that depends on values and sequences: the exact floor scaling at intermediate levels, comparison against the raw pixel rather than the faded one, disabled keying, arrival order, and the one-per-cycle rate over a burst.

// File: rtl/pix_fade_pkg.sv
package pix_fade_pkg;

  localparam int PIX_W   = 16;
  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;
  localparam int LEVEL_W = 6;
  localparam int CHAN_W  = 6;               // widest field
  localparam int PROD_W  = CHAN_W + LEVEL_W + 1;

  typedef struct packed {
    logic [RED_W-1:0] red;
    logic [GRN_W-1:0] grn;
    logic [BLU_W-1:0] blu;
  } rgb565_t;

  // floor(c * (lvl+1) / 2**LEVEL_W); lvl+1 needs one extra bit
  function automatic logic [CHAN_W-1:0] fade_chan(
    input logic [CHAN_W-1:0]  c,
    input logic [LEVEL_W-1:0] lvl
  );
    logic [LEVEL_W:0]   lvl_p1;
    logic [PROD_W-1:0]  prod;
    lvl_p1 = {1'b0, lvl} + {{LEVEL_W{1'b0}}, 1'b1};
    prod   = PROD_W'(c) * PROD_W'(lvl_p1);
    return prod[LEVEL_W +: CHAN_W];
  endfunction

  function automatic rgb565_t fade_pixel(input rgb565_t p, input logic [LEVEL_W-1:0] lvl);
    rgb565_t            o;
    logic [CHAN_W-1:0]  r6, g6, b6;
    r6 = fade_chan(CHAN_W'(p.red), lvl);
    g6 = fade_chan(CHAN_W'(p.grn), lvl);
    b6 = fade_chan(CHAN_W'(p.blu), lvl);
    o.red = r6[RED_W-1:0];
    o.grn = g6[GRN_W-1:0];
    o.blu = b6[BLU_W-1:0];
    return o;
  endfunction

endpackage

// File: rtl/pix_fade_scale.sv
module pix_fade_scale
  import pix_fade_pkg::*;
(
  input  logic [PIX_W-1:0]   pix_in,
  input  logic [LEVEL_W-1:0] level,
  output logic [PIX_W-1:0]   pix_out
);

  rgb565_t in_s, out_s;

  always_comb begin
    in_s    = rgb565_t'(pix_in);
    out_s   = fade_pixel(in_s, level);
    pix_out = PIX_W'(out_s);
  end

endmodule

// File: rtl/pix_key_cmp.sv
module pix_key_cmp
  import pix_fade_pkg::*;
(
  input  logic [PIX_W-1:0] pix_raw,
  input  logic [PIX_W-1:0] key,
  input  logic             enable,
  output logic             hit
);

  always_comb hit = enable && (pix_raw == key);

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              dn_ack,
  output logic              dn_stb,
  output logic [DATA_W-1:0] dn_data,
  output logic              can_take,
  output logic              drain
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // drain and can_take depend on full_q and dn_ack, never on the upstream strobe
  assign drain    = full_q && dn_ack;
  assign can_take = !full_q || dn_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b1;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= load_data;
    end
  end

  assign dn_stb  = full_q;
  assign dn_data = data_q;

endmodule

// File: rtl/pix_fade_key.sv
module pix_fade_key
  import pix_fade_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] fade_level,
  input  logic [PIX_W-1:0]   key_color,
  input  logic               key_enable,
  input  logic               up_stb,
  output logic               up_ack,
  input  logic [PIX_W-1:0]   up_pixel,
  input  logic [ADDR_W-1:0]  up_addr,
  output logic               dn_stb,
  input  logic               dn_ack,
  output logic [PIX_W-1:0]   dn_pixel,
  output logic [ADDR_W-1:0]  dn_addr
);

  localparam int SLOT_W = PIX_W + ADDR_W;

  // named internal events, observed by the bound checker
  logic              ev_accept;
  logic              ev_keyhit;
  logic              ev_load;
  logic              ev_drain;
  logic              can_take;
  logic [PIX_W-1:0]  faded;
  logic [SLOT_W-1:0] slot_out;

  pix_fade_scale u_scale (
    .pix_in  (up_pixel),
    .level   (fade_level),
    .pix_out (faded)
  );

  pix_key_cmp u_key (
    .pix_raw (up_pixel),
    .key     (key_color),
    .enable  (key_enable),
    .hit     (ev_keyhit)
  );

  assign up_ack    = can_take;
  assign ev_accept = up_stb && up_ack;
  assign ev_load   = ev_accept && !ev_keyhit;   // a keyed pixel is consumed, not stored

  pix_out_stage #(.DATA_W(SLOT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (ev_load),
    .load_data ({faded, up_addr}),
    .dn_ack    (dn_ack),
    .dn_stb    (dn_stb),
    .dn_data   (slot_out),
    .can_take  (can_take),
    .drain     (ev_drain)
  );

  assign dn_pixel = slot_out[SLOT_W-1 -: PIX_W];
  assign dn_addr  = slot_out[ADDR_W-1:0];

endmodule

// File: rtl/pix_fade_key_chk.sv
module pix_fade_key_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [5:0]        fade_level,
  input logic              key_enable,
  input logic              up_stb,
  input logic              up_ack,
  input logic [15:0]       up_pixel,
  input logic [ADDR_W-1:0] up_addr,
  input logic              dn_stb,
  input logic              dn_ack,
  input logic [15:0]       dn_pixel,
  input logic [ADDR_W-1:0] dn_addr,
  input logic              ev_accept,
  input logic              ev_keyhit
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    dn_stb && !dn_ack |=> dn_stb && $stable(dn_pixel) && $stable(dn_addr)); // R9

  AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    dn_stb && !dn_ack |-> !up_ack); // R10

  AST_ACK_OPEN: assert property (@(posedge clk) disable iff (rst)
    !dn_stb || dn_ack |-> up_ack); // R10

  AST_KEY_DROPPED: assert property (@(posedge clk) disable iff (rst)
    ev_accept && ev_keyhit && !dn_stb |=> !dn_stb); // R5

  AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !ev_keyhit |=> dn_stb); // R11

  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !ev_keyhit |=> dn_addr == $past(up_addr)); // R8

  AST_KEY_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !key_enable |=> dn_stb); // R6

  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !ev_keyhit && fade_level == 6'd63 |=> dn_pixel == $past(up_pixel)); // R4

  AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ev_accept && !ev_keyhit && fade_level == 6'd0 |=> dn_pixel == 16'h0000); // R3

endmodule

bind pix_fade_key pix_fade_key_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fade_level (fade_level),
  .key_enable (key_enable),
  .up_stb     (up_stb),
  .up_ack     (up_ack),
  .up_pixel   (up_pixel),
  .up_addr    (up_addr),
  .dn_stb     (dn_stb),
  .dn_ack     (dn_ack),
  .dn_pixel   (dn_pixel),
  .dn_addr    (dn_addr),
  .ev_accept  (ev_accept),
  .ev_keyhit  (ev_keyhit)
);

// File: tb/test_pix_fade_key.sv
module test_pix_fade_key;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int ADDR_W     = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [5:0]        fade_level = 6'd63;
  logic [15:0]       key_color  = 16'h0000;
  logic              key_enable = 1'b0;
  logic              up_stb = 1'b0;
  logic              up_ack;
  logic [15:0]       up_pixel = 16'h0000;
  logic [ADDR_W-1:0] up_addr  = '0;
  logic              dn_stb;
  logic              dn_ack = 1'b0;
  logic [15:0]       dn_pixel;
  logic [ADDR_W-1:0] dn_addr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [15:0]       cap_pix  [0:63];
  logic [ADDR_W-1:0] cap_addr [0:63];
  int                cap_n = 0;

  pix_fade_key #(.ADDR_W(ADDR_W)) i_pix_fade_key (
    .clk(clk), .rst(rst), .fade_level(fade_level), .key_color(key_color),
    .key_enable(key_enable), .up_stb(up_stb), .up_ack(up_ack),
    .up_pixel(up_pixel), .up_addr(up_addr), .dn_stb(dn_stb), .dn_ack(dn_ack),
    .dn_pixel(dn_pixel), .dn_addr(dn_addr)
  );

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // downstream monitor: samples one time unit before each rising edge
  always begin
    @(negedge clk);
    #(HALF - 1);
    if (dn_stb && dn_ack && cap_n < 64) begin
      cap_pix[cap_n]  = dn_pixel;
      cap_addr[cap_n] = dn_addr;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [15:0] model(input logic [15:0] p, input int n);
    int r, g, b;
    r = (int'(p[15:11]) * (n + 1)) / 64;
    g = (int'(p[10:5])  * (n + 1)) / 64;
    b = (int'(p[4:0])   * (n + 1)) / 64;
    return {r[4:0], g[5:0], b[4:0]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the transfer
  task automatic push(input logic [15:0] p, input logic [ADDR_W-1:0] a);
    bit ok;
    up_stb = 1'b1; up_pixel = p; up_addr = a;
    forever begin
      #(HALF - 1);
      ok = up_ack;
      @(negedge clk);
      if (ok) break;
    end
    up_stb = 1'b0;
  endtask

  task automatic settle();
    dn_ack = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #(HALF - 1);
    check(dn_stb == 1'b0, "R1 dn_stb after reset", dn_stb, 0);
    check(up_ack == 1'b1, "R1 up_ack after reset", up_ack, 1);
    @(negedge clk);
  endtask

  task automatic t_scale();
    logic [15:0] pats [0:4];
    int lvls [0:2];
    pats[0] = 16'hFFFF; pats[1] = 16'h0841; pats[2] = 16'hA5C3;
    pats[3] = 16'h7BEF; pats[4] = 16'hF81F;
    lvls[0] = 31; lvls[1] = 1; lvls[2] = 47;
    dn_ack = 1'b1; key_enable = 1'b0;
    for (int li = 0; li < 3; li++) begin
      fade_level = 6'(lvls[li]);
      cap_n = 0;
      for (int i = 0; i < 5; i++) push(pats[i], ADDR_W'(24'h100 + i));
      repeat (2) @(negedge clk);
      check(cap_n == 5, "R2 count", cap_n, 5);
      for (int i = 0; i < 5; i++) begin
        check(cap_pix[i] == model(pats[i], lvls[li]), "R2 scaled pixel",
              cap_pix[i], model(pats[i], lvls[li]));
        check(cap_addr[i] == ADDR_W'(24'h100 + i), "R8 address", cap_addr[i], 24'h100 + i);
      end
    end
  endtask

  task automatic t_ends();
    dn_ack = 1'b1; key_enable = 1'b0;
    fade_level = 6'd0; cap_n = 0;
    push(16'hFFFF, 24'h11); push(16'h1234, 24'h12);
    repeat (2) @(negedge clk);
    check(cap_n == 2 && cap_pix[0] == 16'h0 && cap_pix[1] == 16'h0, "R3 black", cap_pix[0], 0);
    fade_level = 6'd63; cap_n = 0;
    push(16'hFFFF, 24'h21); push(16'h1234, 24'h22);
    repeat (2) @(negedge clk);
    check(cap_n == 2 && cap_pix[0] == 16'hFFFF, "R4 unchanged", cap_pix[0], 16'hFFFF);
    check(cap_pix[1] == 16'h1234, "R4 unchanged", cap_pix[1], 16'h1234);
  endtask

  task automatic t_key_drop();
    int t0;
    dn_ack = 1'b1; fade_level = 6'd63;
    key_color = 16'h07E0; key_enable = 1'b1; cap_n = 0;
    push(16'h1111, 24'h31);
    t0 = cyc;
    push(16'h07E0, 24'h32);
    check(cyc - t0 == 1, "R5 keyed pixel consumed in one cycle", cyc - t0, 1);
    push(16'h2222, 24'h33);
    repeat (2) @(negedge clk);
    check(cap_n == 2, "R5 keyed pixel dropped", cap_n, 2);
    check(cap_pix[0] == 16'h1111 && cap_pix[1] == 16'h2222, "R5 survivors", cap_pix[1], 16'h2222);
    check(cap_addr[1] == 24'h33, "R5 survivor address", cap_addr[1], 24'h33);
  endtask

  task automatic t_key_off();
    dn_ack = 1'b1; fade_level = 6'd15;
    key_color = 16'h07E0; key_enable = 1'b0; cap_n = 0;
    push(16'h07E0, 24'h41);
    repeat (2) @(negedge clk);
    check(cap_n == 1, "R6 key disabled forwards", cap_n, 1);
    check(cap_pix[0] == model(16'h07E0, 15), "R6 scaled", cap_pix[0], model(16'h07E0, 15));
  endtask

  task automatic t_key_raw();
    dn_ack = 1'b1; fade_level = 6'd0;
    key_color = 16'h0000; key_enable = 1'b1; cap_n = 0;
    push(16'h1234, 24'h51);
    push(16'h0000, 24'h52);
    repeat (2) @(negedge clk);
    check(cap_n == 1, "R7 only raw match dropped", cap_n, 1);
    check(cap_pix[0] == 16'h0000 && cap_addr[0] == 24'h51, "R7 faded-to-key pixel kept",
          cap_addr[0], 24'h51);
    key_enable = 1'b0;
  endtask

  task automatic t_stall();
    dn_ack = 1'b0; fade_level = 6'd63; key_enable = 1'b0; cap_n = 0;
    push(16'hBEEF, 24'h61);
    for (int k = 0; k < 3; k++) begin
      #(HALF - 1);
      check(dn_stb == 1'b1, "R9 stb held", dn_stb, 1);
      check(dn_pixel == 16'hBEEF && dn_addr == 24'h61, "R9 data held", dn_pixel, 16'hBEEF);
      check(up_ack == 1'b0, "R10 ack low while full", up_ack, 0);
      @(negedge clk);
    end
    dn_ack = 1'b1;
    #(HALF - 1);
    check(up_ack == 1'b1, "R10 ack high while draining", up_ack, 1);
    @(negedge clk);
    check(cap_n == 1, "R9 single delivery", cap_n, 1);
  endtask

  task automatic t_latency();
    dn_ack = 1'b1; fade_level = 6'd63; cap_n = 0;
    push(16'h5A5A, 24'h71);
    #(HALF - 1);
    check(dn_stb == 1'b1 && dn_pixel == 16'h5A5A, "R11 next-cycle output", dn_pixel, 16'h5A5A);
    @(negedge clk);
  endtask

  task automatic t_stream();
    int t0;
    dn_ack = 1'b1; fade_level = 6'd63; key_enable = 1'b0; cap_n = 0;
    t0 = cyc;
    for (int i = 0; i < 8; i++) push(16'(16'h0300 + i * 7), ADDR_W'(24'h80 + i));
    check(cyc - t0 == 8, "R12 one per cycle", cyc - t0, 8);
    repeat (2) @(negedge clk);
    check(cap_n == 8, "R12 count", cap_n, 8);
    for (int i = 0; i < 8; i++)
      check(cap_pix[i] == 16'(16'h0300 + i * 7) && cap_addr[i] == ADDR_W'(24'h80 + i),
            "R12 order", cap_addr[i], 24'h80 + i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_scale();    settle();
    t_ends();     settle();
    t_key_drop(); settle();
    t_key_off();  settle();
    t_key_raw();  settle();
    t_stall();    settle();
    t_latency();  settle();
    t_stream();   settle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule